// File: doc/BRIEF.md
# Dual Character FIFO with Level Interrupts

This block sits between a host and a UART character engine and buffers characters in both directions. The transmit FIFO holds 8-bit characters that the host pushes. The serializer pops them. The receive FIFO holds each incoming character together with its error bits. The deserializer pushes entries and the host pops them. Each FIFO holds up to 16 entries and reports its fill count, from 0 up to and including 16.

Each FIFO has a host-programmed 5-bit level that drives a level-sensitive interrupt:
- The transmit interrupt asks for more data while the FIFO is at or below its level.
- The receive interrupt asks for service once the FIFO has reached its level.

A character that arrives while the receive FIFO is full is lost, and a sticky overflow flag records the loss until the host clears it. Each FIFO has its own active-low flush input. Clearing the global FIFO enable reduces both directions to a single-entry buffer.

Top module: `char_fifo_pair`

## Requirements
- R1: After global reset both fill counts are 0, both `*_avail` outputs are low and `rx_ovf` is low. An accepted push raises a count by one, an accepted pop lowers it by one, and a count never exceeds 16. `tx_avail` (transmitter has pending data) is high exactly when `tx_count` is non-zero, and `rx_avail` likewise.
- R2: Entries leave each FIFO in the order they entered. The receive FIFO returns on `rx_err_out` the error bits that were pushed with the same character. The head entry is presented combinationally on the data outputs whenever the FIFO is not empty.
- R3: With FIFOs enabled, a push to a transmit FIFO holding 16 entries is dropped and its contents are unchanged, even if a pop happens in the same cycle.
- R4: A receive push while the receive FIFO is full is discarded and sets `rx_ovf`. `rx_ovf` stays set until a cycle with `rx_ovf_clr` high and no new overflow; an overflow in the same cycle as the clear wins. An RX flush does not clear `rx_ovf`.
- R5: A push and a pop in the same cycle, when neither is blocked, leave the fill count unchanged and still advance the data.
- R6: `tx_irq` is high exactly when `fifo_en` is high and `tx_count <= tx_level`.
- R7: `rx_irq` is high exactly when `fifo_en` is high and `rx_count >= rx_level`.
- R8: Holding `tx_flush_n` low at a clock edge empties the transmit FIFO and ignores its push and pop, without affecting the receive FIFO. `rx_flush_n` does the same for the receive FIFO.
- R9: With `fifo_en` low each FIFO accepts at most one entry. A second transmit push is dropped, a second receive push overflows, and both interrupts are low.
- R10: A pop from an empty FIFO is ignored and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| fifo_en | input | 1 | 1: 16-entry FIFOs; 0: single-entry buffers |
| tx_flush_n | input | 1 | Synchronous active-low transmit FIFO flush |
| rx_flush_n | input | 1 | Synchronous active-low receive FIFO flush |
| tx_push | input | 1 | Host writes a character |
| tx_din | input | 8 | Character written by host |
| tx_pop | input | 1 | Serializer takes the head character |
| tx_dout | output | 8 | Head character of transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO non-empty (transmitter busy) |
| tx_full | output | 1 | Transmit FIFO at capacity |
| tx_count | output | 5 | Transmit fill count 0..16 |
| tx_level | input | 5 | Transmit interrupt level 0..16 |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_push | input | 1 | Deserializer delivers a character |
| rx_din | input | 8 | Received character |
| rx_err_in | input | 3 | Error bits for received character |
| rx_pop | input | 1 | Host reads the head entry |
| rx_dout | output | 8 | Head character of receive FIFO |
| rx_err_out | output | 3 | Error bits of head entry |
| rx_avail | output | 1 | Receive FIFO non-empty |
| rx_count | output | 5 | Receive fill count 0..16 |
| rx_level | input | 5 | Receive interrupt level 0..16 |
| rx_irq | output | 1 | Receive level interrupt |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| rx_ovf_clr | input | 1 | Clears `rx_ovf` |

## Verification
A wrong fill count shows on `tx_count` or `rx_count` on the very next clock edge. It also shifts the interrupt outputs, because they compare that count with the level. A corrupted read or write pointer does not disturb the count. Instead it shows on the head data outputs, once the next entry is expected at the head, so the bench compares the head entry before every edge. A lost or falsely cleared overflow flag shows on `rx_ovf` one edge after the offending push or clear.

// File: rtl/char_fifo_pair.sv
module char_fifo_pair #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          tx_flush_n,
  input  logic          rx_flush_n,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic          tx_avail,
  output logic          tx_full,
  output logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_level,
  output logic          tx_irq,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic [EW-1:0] rx_err_in,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [EW-1:0] rx_err_out,
  output logic          rx_avail,
  output logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_level,
  output logic          rx_irq,
  output logic          rx_ovf,
  input  logic          rx_ovf_clr
);

  localparam int RW = DW + EW;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [CW-1:0] cap;
  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  // transmit side
  logic [DW-1:0] tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic          tx_acc, tx_take;

  assign tx_full  = tx_count >= cap;
  assign tx_avail = tx_count != '0;
  assign tx_acc   = tx_flush_n && tx_push && !tx_full;
  assign tx_take  = tx_flush_n && tx_pop && tx_avail;
  assign tx_dout  = tx_mem[tx_rp];
  assign tx_irq   = fifo_en && (tx_count <= tx_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_count <= '0;
      tx_wp    <= '0;
      tx_rp    <= '0;
    end else if (!tx_flush_n) begin
      tx_count <= '0;
      tx_wp    <= '0;
      tx_rp    <= '0;
    end else begin
      if (tx_acc)  tx_wp <= bump(tx_wp);
      if (tx_take) tx_rp <= bump(tx_rp);
      if (tx_acc && !tx_take)      tx_count <= tx_count + CW'(1);
      else if (!tx_acc && tx_take) tx_count <= tx_count - CW'(1);
    end
  end

  always_ff @(posedge clk)
    if (tx_acc) tx_mem[tx_wp] <= tx_din;

  // receive side
  logic [RW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic          rx_full, rx_acc, rx_take, rx_drop;

  assign rx_full  = rx_count >= cap;
  assign rx_avail = rx_count != '0;
  assign rx_acc   = rx_flush_n && rx_push && !rx_full;
  assign rx_drop  = rx_flush_n && rx_push && rx_full;
  assign rx_take  = rx_flush_n && rx_pop && rx_avail;
  assign {rx_err_out, rx_dout} = rx_mem[rx_rp];
  assign rx_irq   = fifo_en && (rx_count >= rx_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_count <= '0;
      rx_wp    <= '0;
      rx_rp    <= '0;
    end else if (!rx_flush_n) begin
      rx_count <= '0;
      rx_wp    <= '0;
      rx_rp    <= '0;
    end else begin
      if (rx_acc)  rx_wp <= bump(rx_wp);
      if (rx_take) rx_rp <= bump(rx_rp);
      if (rx_acc && !rx_take)      rx_count <= rx_count + CW'(1);
      else if (!rx_acc && rx_take) rx_count <= rx_count - CW'(1);
    end
  end

  always_ff @(posedge clk)
    if (rx_acc) rx_mem[rx_wp] <= {rx_err_in, rx_din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_ovf <= 1'b0;
    else if (rx_drop)    rx_ovf <= 1'b1;
    else if (rx_ovf_clr) rx_ovf <= 1'b0;
  end

  // checks
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  assert_tx_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_n && fifo_en && tx_count == CW'(DEPTH) && tx_push && !tx_pop)
      |=> (tx_count == CW'(DEPTH) && $stable(tx_dout)));

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_n && rx_push && rx_count >= cap) |=> rx_ovf);

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !rx_ovf_clr) |=> rx_ovf);

  assert_pushpop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_n && tx_push && tx_pop && tx_count != '0 && tx_count < cap)
      |=> $stable(tx_count));

  assert_tx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_flush_n |=> (tx_count == '0));

  assert_rx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flush_n |=> (rx_count == '0));

  assert_single_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !(tx_irq || rx_irq));

  assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 && !rx_push) |=> (rx_count == '0));

endmodule

// File: tb/tb_char_fifo_pair.sv
module tb_char_fifo_pair;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, fifo_en = 1'b1, tx_flush_n = 1'b1, rx_flush_n = 1'b1;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, rx_ovf_clr = 0;
  logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic [2:0] rx_err_in = '0, rx_err_out;
  logic [4:0] tx_level = 5'd4, rx_level = 5'd8, tx_count, rx_count;
  logic tx_avail, tx_full, tx_irq, rx_avail, rx_irq, rx_ovf;

  char_fifo_pair dut (.*);

  int vectors = 0, fails = 0;
  logic [7:0]  tq[$];
  logic [10:0] rq[$];
  bit m_ovf = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int capf();
    return fifo_en ? 16 : 1;
  endfunction

  function automatic bit exp_tx_irq();
    return fifo_en && (tq.size() <= int'(tx_level));
  endfunction

  function automatic bit exp_rx_irq();
    return fifo_en && (rq.size() >= int'(rx_level));
  endfunction

  task automatic step(input string ph);
    bit tpush, tpop, rpush, rpop, rdrop;
    if (tq.size() > 0) chk({"R2 tx head ", ph}, tx_dout, tq[0]);
    if (rq.size() > 0) chk({"R2 rx head ", ph}, {rx_err_out, rx_dout}, rq[0]);
    tpush = tx_flush_n && tx_push && tq.size() < capf();
    tpop  = tx_flush_n && tx_pop && tq.size() > 0;
    rpush = rx_flush_n && rx_push && rq.size() < capf();
    rdrop = rx_flush_n && rx_push && rq.size() >= capf();
    rpop  = rx_flush_n && rx_pop && rq.size() > 0;
    @(posedge clk);
    #1;
    if (!tx_flush_n) tq.delete();
    else begin
      if (tpop) void'(tq.pop_front());
      if (tpush) tq.push_back(tx_din);
    end
    if (!rx_flush_n) rq.delete();
    else begin
      if (rpop) void'(rq.pop_front());
      if (rpush) rq.push_back({rx_err_in, rx_din});
    end
    if (rdrop) m_ovf = 1;
    else if (rx_ovf_clr) m_ovf = 0;
    chk({"R1 tx_count ", ph}, tx_count, tq.size());
    chk({"R1 rx_count ", ph}, rx_count, rq.size());
    chk({"R1 tx_avail ", ph}, tx_avail, tq.size() != 0);
    chk({"R6 tx_irq ", ph}, tx_irq, exp_tx_irq());
    chk({"R7 rx_irq ", ph}, rx_irq, exp_rx_irq());
    chk({"R4 rx_ovf ", ph}, rx_ovf, m_ovf);
  endtask

  task automatic idle();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_ovf_clr = 0;
    tx_flush_n = 1; rx_flush_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset tx_count", tx_count, 0);
    chk("R1 reset rx_count", rx_count, 0);
    chk("R1 reset rx_avail", rx_avail, 0);
    chk("R1 reset rx_ovf", rx_ovf, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R10: pop from empty
    idle(); tx_pop = 1; rx_pop = 1; step("R10");
    idle();

    // R3: fill tx to 16, then extra push (with and without pop)
    for (int i = 0; i < 16; i++) begin tx_push = 1; tx_din = 8'(8'hA0 + i); step("R1 fill"); end
    chk("R3 tx_full", tx_full, 1);
    tx_din = 8'hFF; step("R3 drop");
    tx_pop = 1; step("R3 drop with pop");
    // R5: push+pop at 15
    step("R5 hold");
    idle();
    for (int i = 0; i < 15; i++) begin tx_pop = 1; step("R2 drain"); end
    idle();

    // R4: overflow receive
    for (int i = 0; i < 17; i++) begin
      rx_push = 1; rx_din = 8'(i * 7); rx_err_in = 3'(i); step("R4 fill");
    end
    idle(); step("R4 sticky");
    rx_push = 1; rx_ovf_clr = 1; step("R4 set wins");
    idle(); rx_flush_n = 0; step("R8 rx flush keeps ovf");
    idle(); rx_ovf_clr = 1; step("R4 clear");
    idle();

    // R8: independent flush
    tx_push = 1; rx_push = 1; step("R8 load"); step("R8 load");
    idle(); tx_flush_n = 0; tx_push = 1; step("R8 tx flush");
    chk("R8 rx untouched", rx_count, 2);
    idle(); rx_flush_n = 0; step("R8 rx flush");

    // R9: single-buffer mode
    idle(); fifo_en = 0;
    tx_push = 1; rx_push = 1; tx_din = 8'h5A; rx_din = 8'h3C;
    step("R9 first"); step("R9 second dropped");
    chk("R9 tx_count", tx_count, 1);
    chk("R9 rx overflow", rx_ovf, 1);
    idle(); tx_pop = 1; rx_pop = 1; rx_ovf_clr = 1; step("R9 drain");
    idle(); fifo_en = 1;

    // R6/R7: level sweep
    for (int l = 0; l <= 16; l++) begin
      tx_level = 5'(l); rx_level = 5'(16 - l);
      tx_push = 1; rx_push = 1; tx_din = 8'(l); rx_din = 8'(l);
      step("R6 R7 sweep");
    end
    idle(); tx_flush_n = 0; rx_flush_n = 0; rx_ovf_clr = 1; step("sweep cleanup");
    idle();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      tx_push    = ($urandom_range(0, 99) < 55);
      tx_pop     = ($urandom_range(0, 99) < 45);
      rx_push    = ($urandom_range(0, 99) < 50);
      rx_pop     = ($urandom_range(0, 99) < 45);
      rx_ovf_clr = ($urandom_range(0, 99) < 5);
      tx_flush_n = ($urandom_range(0, 199) != 0);
      rx_flush_n = ($urandom_range(0, 199) != 0);
      if ($urandom_range(0, 299) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 49) == 0) tx_level = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 49) == 0) rx_level = 5'($urandom_range(0, 16));
      tx_din = 8'($urandom); rx_din = 8'($urandom); rx_err_in = 3'($urandom);
      step("R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule